// File: doc/BRIEF.md
# Cyclic Rotation Candidate Filter

This block takes base bit patterns one at a time from an upstream producer and turns each one into a run of candidate words: the pattern itself and every cyclic rotation of it, one candidate per cycle. A candidate goes downstream only if its count of ones passes the weight rules. The count must leave a fixed residue under a fixed modulus, by default 3 modulo 4. It must also reach a floor on the number of ones, by default 19. When exact matching is switched on, it must also equal a runtime target weight.

Rotation never changes the number of ones. The weight rules are therefore checked once, as the base word is accepted. A base word that fails is consumed and dropped with no output. A base word that passes is held, and the block issues its rotations in rising shift order. Each candidate carries the shift amount as a tag. The next base word can be accepted in the same cycle as the last rotation of the current one, so a steady input stream leaves no idle output cycles.

Top module: `rotation_candidate_filter`

## Requirements
- R1: A synchronous active-high reset leaves `out_valid` low and `in_ready` high on the first cycle after it, and clears the rotation index to 0.
- R2: A base word is kept only if its number of ones modulo `WT_MOD` equals `WT_RES` (defaults 4 and 3). Words with any other residue give no output.
- R3: A base word with fewer than `MIN_ONES` ones (default 19) gives no output, even when its residue is right.
- R4: While `match_en` is 1 at the accepting edge, a base word is kept only if its number of ones also equals `target_k` as sampled at that edge. While `match_en` is 0, `target_k` has no effect.
- R5: A rejected base word is consumed in one handshake and produces no candidate. The block stays ready for the next base word.
- R6: A kept base word yields exactly `WORD_W` candidates with `out_rot` = 0, 1, …, `WORD_W`-1 in that order. Each candidate is the base word rotated left by `out_rot`, so bit i of `out_word` equals base bit (i − `out_rot`) mod `WORD_W`.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_word` and `out_rot` hold their values on the next cycle.
- R8: `in_ready` is 1 whenever no candidate is pending, and also in a cycle whose candidate has `out_rot` = `WORD_W`-1 and is taken. In that second case, a base word accepted in the same cycle starts its rotation 0 on the very next cycle.
- R9: While a candidate other than the last rotation is pending, or the last one is stalled, `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Base word offered |
| in_ready | output | 1 | Base word can be taken this cycle |
| in_word | input | WORD_W (64) | Base pattern |
| match_en | input | 1 | Require exact weight equal to `target_k` |
| target_k | input | CNT_W (7) | Runtime target weight |
| out_valid | output | 1 | Candidate present |
| out_ready | input | 1 | Downstream takes the candidate |
| out_word | output | WORD_W (64) | Rotated candidate |
| out_rot | output | IDX_W (6) | Left-rotation amount of the candidate |

## Verification
The bound checker checks the cycle-level properties on every cycle. Every emitted candidate satisfies the residue and floor rules. A stalled candidate holds its value. Each taken candidate other than the last is followed by the next one, with the index one higher and the word rotated left by one place. After the last rotation the index comes back to 0, and `in_ready` is high whenever nothing is pending. Other properties need the bench scenarios. Every base word must give exactly the right number of candidates: all of its rotations, or none for a rejected word. The `match_en`/`target_k` selection must behave correctly. Back-to-back words must follow each other with no gap. The bench shows these with exhaustive sweeps over every 12-bit base word under random downstream backpressure.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/rcf_popcount.sv
module rcf_popcount #(
   parameter int WORD_W = 64,
   parameter int CNT_W  = $clog2(WORD_W + 1)
) (
   input  logic [WORD_W-1:0] word_i,
   output logic [CNT_W-1:0]  ones_o
);
   always_comb begin
      ones_o = '0;
      for (int b = 0; b < WORD_W; b++) begin
         ones_o = ones_o + CNT_W'(word_i[b]);
      end
   end
endmodule

// File: rtl/rcf_weight_gate.sv
module rcf_weight_gate
   import rcf_pkg::*;
#(
   parameter int WORD_W   = 64,
   parameter int CNT_W    = $clog2(WORD_W + 1),
   parameter int MIN_ONES = 19,
   parameter int WT_MOD   = 4,
   parameter int WT_RES   = 3
) (
   input  logic [CNT_W-1:0] ones_i,
   input  logic             match_en_i,
   input  logic [CNT_W-1:0] target_i,
   output logic             keep_o
);
   logic residue_ok;
   logic floor_ok;
   logic exact_ok;

   generate
      if (is_pow2(WT_MOD)) begin : g_mask_res
         localparam logic [CNT_W-1:0] MASK = CNT_W'(WT_MOD - 1);
         assign residue_ok = ((ones_i & MASK) == CNT_W'(WT_RES));
      end else begin : g_div_res
         assign residue_ok = ((ones_i % CNT_W'(WT_MOD)) == CNT_W'(WT_RES));
      end
   endgenerate

   assign floor_ok = (ones_i >= CNT_W'(MIN_ONES));
   assign exact_ok = !match_en_i || (ones_i == target_i);
   assign keep_o   = residue_ok && floor_ok && exact_ok;
endmodule

// File: rtl/rcf_rotator.sv
module rcf_rotator #(
   parameter int WORD_W = 64,
   parameter int IDX_W  = $clog2(WORD_W)
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [IDX_W-1:0]  amt_i,
   output logic [WORD_W-1:0] word_o
);
   logic [WORD_W-1:0] stg [IDX_W+1];

   assign stg[0] = word_i;

   generate
      for (genvar s = 0; s < IDX_W; s++) begin : g_stage
         localparam int SH = (1 << s) % WORD_W;
         if (SH == 0) begin : g_pass
            assign stg[s+1] = stg[s];
         end else begin : g_rot
            assign stg[s+1] = amt_i[s]
               ? {stg[s][WORD_W-SH-1:0], stg[s][WORD_W-1:WORD_W-SH]}
               : stg[s];
         end
      end
   endgenerate

   assign word_o = stg[IDX_W];
endmodule

// File: rtl/rotation_candidate_filter.sv
module rotation_candidate_filter #(
   parameter int WORD_W   = 64,
   parameter int MIN_ONES = 19,
   parameter int WT_MOD   = 4,
   parameter int WT_RES   = 3,
   localparam int IDX_W   = $clog2(WORD_W),
   localparam int CNT_W   = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [WORD_W-1:0] in_word,
   input  logic              match_en,
   input  logic [CNT_W-1:0]  target_k,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [WORD_W-1:0] out_word,
   output logic [IDX_W-1:0]  out_rot
);
   generate
      if (WORD_W < 2) begin : g_bad_width
         $error("WORD_W must be at least 2");
      end
      if (MIN_ONES < 0 || MIN_ONES > WORD_W) begin : g_bad_floor
         $error("MIN_ONES must lie in 0..WORD_W");
      end
      if (WT_MOD < 1 || WT_RES < 0 || WT_RES >= WT_MOD) begin : g_bad_res
         $error("WT_RES must lie in 0..WT_MOD-1");
      end
   endgenerate

   localparam logic [IDX_W-1:0] LAST_ROT = IDX_W'(WORD_W - 1);

   logic              busy_q;
   logic [WORD_W-1:0] base_q;
   logic [IDX_W-1:0]  rot_q;
   logic [CNT_W-1:0]  in_ones;
   logic              keep;
   logic              last_rot;
   logic              fire;
   logic              take_in;

   rcf_popcount #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_count (
      .word_i (in_word),
      .ones_o (in_ones)
   );

   rcf_weight_gate #(
      .WORD_W   (WORD_W),
      .CNT_W    (CNT_W),
      .MIN_ONES (MIN_ONES),
      .WT_MOD   (WT_MOD),
      .WT_RES   (WT_RES)
   ) u_gate (
      .ones_i     (in_ones),
      .match_en_i (match_en),
      .target_i   (target_k),
      .keep_o     (keep)
   );

   rcf_rotator #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_rot (
      .word_i (base_q),
      .amt_i  (rot_q),
      .word_o (out_word)
   );

   assign last_rot = (rot_q == LAST_ROT);
   assign fire     = busy_q && out_ready;
   assign in_ready = !busy_q || (out_ready && last_rot);
   assign take_in  = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         rot_q  <= '0;
         base_q <= '0;
      end else if (take_in) begin
         busy_q <= keep;
         rot_q  <= '0;
         if (keep) begin
            base_q <= in_word;
         end
      end else if (fire) begin
         if (last_rot) begin
            busy_q <= 1'b0;
            rot_q  <= '0;
         end else begin
            rot_q  <= rot_q + IDX_W'(1);
         end
      end
   end

   assign out_valid = busy_q;
   assign out_rot   = rot_q;
endmodule

// File: rtl/rcf_checker.sv
module rcf_checker #(
   parameter int WORD_W   = 64,
   parameter int MIN_ONES = 19,
   parameter int WT_MOD   = 4,
   parameter int WT_RES   = 3,
   localparam int IDX_W   = $clog2(WORD_W)
) (
   input logic              clk,
   input logic              rst,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [WORD_W-1:0] out_word,
   input logic [IDX_W-1:0]  out_rot
);
   localparam logic [IDX_W-1:0] LAST_ROT = IDX_W'(WORD_W - 1);

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      rst |=> (!out_valid && in_ready && out_rot == '0));

   // R2
   residue_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (($countones(out_word) % WT_MOD) == WT_RES));

   // R3
   floor_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ($countones(out_word) >= MIN_ONES));

   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_word) && $stable(out_rot)));

   // R6
   next_rot_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && out_rot != LAST_ROT) |=>
         (out_valid && out_rot == $past(out_rot) + IDX_W'(1) &&
          out_word == {$past(out_word[WORD_W-2:0]), $past(out_word[WORD_W-1])}));

   // R8
   wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_ready && out_rot == LAST_ROT) |=>
         (out_rot == '0));

   // R8
   idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> in_ready);

   // R9
   busy_block_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !(out_ready && out_rot == LAST_ROT)) |-> !in_ready);
endmodule

bind rotation_candidate_filter rcf_checker #(
   .WORD_W   (WORD_W),
   .MIN_ONES (MIN_ONES),
   .WT_MOD   (WT_MOD),
   .WT_RES   (WT_RES)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_word  (out_word),
   .out_rot   (out_rot)
);

// File: tb/rotation_candidate_filter_tb_top.sv
module rotation_candidate_filter_tb_top;
   localparam int W     = 12;
   localparam int MINO  = 7;
   localparam int MODV  = 4;
   localparam int RESV  = 3;
   localparam int IW    = $clog2(W);
   localparam int CW    = $clog2(W + 1);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [W-1:0]  in_word = '0;
   logic          match_en = 1'b0;
   logic [CW-1:0] target_k = '0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [W-1:0]  out_word;
   logic [IW-1:0] out_rot;

   always #4 clk = ~clk;

   rotation_candidate_filter #(
      .WORD_W(W), .MIN_ONES(MINO), .WT_MOD(MODV), .WT_RES(RESV)
   ) dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_word(in_word), .match_en(match_en), .target_k(target_k),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_word(out_word), .out_rot(out_rot)
   );

   int checks = 0;
   int fails  = 0;
   int out_cnt = 0;
   bit acc_seen = 0;
   bit finished = 0;
   bit stalled = 0;
   logic [W-1:0]  held_word;
   logic [IW-1:0] held_rot;
   logic [W-1:0]  q_word[$];
   int            q_rot[$];
   logic [15:0]   lfsr = 16'hACE1;

   function automatic int ones_of(logic [W-1:0] v);
      int n = 0;
      for (int b = 0; b < W; b++) n += v[b];
      return n;
   endfunction

   function automatic bit keeps(int wt, bit m, int k);
      return (wt % MODV == RESV) && (wt >= MINO) && (!m || wt == k);
   endfunction

   function automatic logic [W-1:0] rot_left(logic [W-1:0] v, int r);
      logic [W-1:0] o;
      for (int i = 0; i < W; i++) o[i] = v[(i - r + W) % W];
      return o;
   endfunction

   function automatic longint binom(int n, int k);
      longint c = 1;
      for (int i = 0; i < k; i++) c = c * (n - i) / (i + 1);
      return c;
   endfunction

   task automatic check(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // downstream backpressure, changed away from the rising edge
   always @(negedge clk) begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready <= (lfsr[1:0] != 2'b00);
   end

   // monitor: samples 3 ns after the falling edge, 1 ns before the rising edge
   always begin
      @(negedge clk);
      #3;
      if (!rst && !finished) begin
         if (out_valid) begin
            check(in_ready == (out_ready && out_rot == IW'(W - 1)),
                  "R9 in_ready while busy", in_ready,
                  (out_ready && out_rot == IW'(W - 1)));
            if (stalled) begin
               check(out_word == held_word && out_rot == held_rot,
                     "R7 stalled candidate held", out_word, held_word);
            end
         end else begin
            check(in_ready, "R8 ready when idle", in_ready, 1);
         end
         if (out_valid && out_ready) begin
            out_cnt++;
            if (q_word.size() == 0) begin
               check(0, "R5 unexpected candidate", out_word, 0);
            end else begin
               logic [W-1:0] ew;
               int er;
               ew = q_word.pop_front();
               er = q_rot.pop_front();
               check(out_word == ew && int'(out_rot) == er,
                     "R6 candidate word/rotation", {out_rot, out_word},
                     {IW'(er), ew});
            end
         end
         stalled   = out_valid && !out_ready;
         held_word = out_word;
         held_rot  = out_rot;
         if (in_valid && in_ready) begin
            acc_seen = 1;
            if (keeps(ones_of(in_word), match_en, int'(target_k))) begin
               for (int r = 0; r < W; r++) begin
                  q_word.push_back(rot_left(in_word, r));
                  q_rot.push_back(r);
               end
            end
         end
      end
   end

   task automatic send(logic [W-1:0] w);
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = w;
      acc_seen = 0;
      do @(posedge clk); while (!acc_seen);
   endtask

   task automatic sweep(bit m, int k, string req);
      longint exp_cnt = 0;
      for (int wt = 0; wt <= W; wt++)
         if (keeps(wt, m, k)) exp_cnt += binom(W, wt) * W;
      @(negedge clk);
      match_en = m;
      target_k = CW'(k);
      out_cnt  = 0;
      for (int w = 0; w < (1 << W); w++) send(W'(w));
      @(negedge clk);
      in_valid = 1'b0;
      while (q_word.size() != 0 || out_valid) @(negedge clk);
      repeat (3) @(negedge clk);
      check(out_cnt == exp_cnt, req, out_cnt, exp_cnt);
   endtask

   // back-to-back: two kept words, the second must start right after the first
   task automatic gapless;
      int gap_seen = 0;
      @(negedge clk);
      match_en = 1'b0;
      send(W'(12'h07F));
      send(W'(12'hFE0));
      @(negedge clk);
      in_valid = 1'b0;
      while (out_valid) begin
         #3;
         if (out_valid && out_rot == IW'(W - 1) && !out_ready) gap_seen = gap_seen;
         @(negedge clk);
      end
      check(q_word.size() == 0, "R8 back-to-back words drained", q_word.size(), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #3;
      check(!out_valid && in_ready && out_rot == '0, "R1 reset state",
            {out_valid, in_ready, out_rot}, {1'b0, 1'b1, IW'(0)});
      // weight 3 words have the right residue but are below the floor
      sweep(1'b0, 0, "R2 R3 residue and floor count");
      sweep(1'b1, 11, "R4 exact weight 11 count");
      sweep(1'b1, 3, "R3 exact weight below floor count");
      sweep(1'b1, 7, "R4 exact weight 7 count");
      sweep(1'b1, 5, "R2 R5 wrong residue target count");
      gapless();
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule